// File: doc/BRIEF.md
# Colour-Edge Sharpener

This block steepens the edges in the two colour-difference sample streams (red-difference and blue-difference). Each stream has its own lane. A lane keeps a short sliding window of recent samples and builds a correction term from the negated second difference around the window centre. It scales that term by a programmable gain and drops it to zero when its magnitude is below a programmable coring level. The scaled term is then added to the centre sample.

The sum is limited to the smallest and largest sample in the span used for the derivative. A transition can therefore steepen, but it never rings past the levels on either side of it. Such ringing would show up on screen as false colours.

The derivative span can be set to one, two or four samples, so a narrow-band decoded signal and a wide-band component signal can both be sharpened. All arithmetic saturates at the sample range instead of wrapping. Samples enter with a valid strobe, and a matching strobe comes out a fixed number of clock cycles later. The configuration inputs are static and are meant to change only while no samples are in flight.

Top module: `chroma_edge_sharpen`

## Requirements
- R1: `out_valid` is high in exactly those cycles that follow by three clock edges a cycle in which `in_valid` was sampled high.
- R2: The output for the n-th accepted sample (counting from 0 after reset) is built around centre sample n-4, and sample positions before the first accepted sample count as 0. With `gain` = 0 the output equals that centre sample.
- R3: The derivative is d = sat(2c - a - b), where c is the centre sample and a, b are the samples k positions after and before it. The span code `span_sel` selects k: 2'b00 gives k=1, 2'b01 gives k=2, and 2'b10 or 2'b11 give k=4.
- R4: The correction is sat(floor((d*g + 4) / 8)), where g is the unsigned 4-bit `gain` in steps of 1/8. Here sat() limits a value to the signed 10-bit range -512..511.
- R5: A correction whose magnitude is less than the unsigned `core_lvl` becomes 0. A `core_lvl` of 0 keeps every correction, and a `core_lvl` above 512 removes them all.
- R6: The output is sat(c + correction), clamped to the minimum and maximum of the 2k+1 samples centred on c.
- R7: The red-difference lane and the blue-difference lane compute independently, with identical rules.
- R8: While `out_valid` is low, `out_cr` and `out_cb` keep their last values.
- R9: During reset, `out_valid` is 0 and both output samples are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_cr | input | 10 | Red-difference sample, signed |
| in_cb | input | 10 | Blue-difference sample, signed |
| span_sel | input | 2 | Derivative span code |
| gain | input | 4 | Correction gain, unsigned, 1/8 steps |
| core_lvl | input | 10 | Coring threshold, unsigned |
| out_valid | output | 1 | Output sample strobe |
| out_cr | output | 10 | Sharpened red-difference sample, signed |
| out_cb | output | 10 | Sharpened blue-difference sample, signed |

## Verification
The bound checker checks three things on every cycle:
- the three-edge strobe alignment and the hold of the outputs between strobes;
- that each output lies within the window minimum and maximum held in the first pipeline stage;
- that a zero gain, or a coring level above the largest possible correction, passes the centre sample through unchanged.

Only the bench's scenarios can show that the arithmetic is right. These scenarios cover the exact second difference for each span code, including the alias code, and the rounding and saturation at full gain with extreme samples. They also cover the coring cutoff at its boundary and the lane-to-lane independence when the two streams carry unrelated data.

// File: rtl/ces_pkg.sv
package ces_pkg;
  // number of colour-difference lanes (red-difference, blue-difference)
  localparam int LANES = 2;

  // derivative span codes; both upper codes select the widest span
  typedef enum logic [1:0] {
    SPAN_NARROW   = 2'b00,
    SPAN_MID      = 2'b01,
    SPAN_WIDE     = 2'b10,
    SPAN_WIDE_ALT = 2'b11
  } span_e;
endpackage

// File: rtl/ces_window.sv
// Sliding sample window with span-dependent tap and range selection.
module ces_window #(
  parameter int W    = 10,
  parameter int KMAX = 4,
  localparam int TAPS = 2 * KMAX + 1,
  localparam int KW   = $clog2(KMAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic signed [W-1:0] din,
  input  logic [KW-1:0]       kval,
  output logic signed [W-1:0] ctr,
  output logic signed [W-1:0] newer,
  output logic signed [W-1:0] older,
  output logic signed [W-1:0] lo,
  output logic signed [W-1:0] hi
);
  // tap 0 is the newest sample, tap TAPS-1 the oldest
  logic signed [W-1:0] tap_q [TAPS];
  logic signed [W-1:0] tap_d [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_comb tap_d[g] = din;
    end else begin : g_body
      always_comb tap_d[g] = tap_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tap_q[g] <= '0;
      else if (shift_en) tap_q[g] <= tap_d[g];
    end
  end

  always_comb begin
    ctr   = tap_q[KMAX];
    newer = tap_q[KMAX - int'(kval)];
    older = tap_q[KMAX + int'(kval)];
    lo    = tap_q[KMAX];
    hi    = tap_q[KMAX];
    for (int j = 0; j < TAPS; j++) begin
      if ((j + int'(kval) >= KMAX) && (j <= KMAX + int'(kval))) begin
        if (tap_q[j] < lo) lo = tap_q[j];
        if (tap_q[j] > hi) hi = tap_q[j];
      end
    end
  end
endmodule

// File: rtl/ces_shaper.sv
// Gain, rounding, coring, add-back and range limiting (combinational).
module ces_shaper #(
  parameter int W  = 10,
  parameter int GW = 4,
  localparam int FRAC = GW - 1,
  localparam int PW   = W + GW + 1
) (
  input  logic signed [W-1:0] ctr,
  input  logic signed [W-1:0] lo,
  input  logic signed [W-1:0] hi,
  input  logic signed [W-1:0] dif,
  input  logic [GW-1:0]       gain,
  input  logic [W-1:0]        core,
  output logic signed [W-1:0] res
);
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC - 1);

  function automatic logic signed [W-1:0] sat_p(input logic signed [PW-1:0] v);
    if (&v[PW-1:W-1] || ~|v[PW-1:W-1]) return v[W-1:0];
    else if (v[PW-1])                  return {1'b1, {(W-1){1'b0}}};
    else                               return {1'b0, {(W-1){1'b1}}};
  endfunction

  logic signed [PW-1:0] prod, prod_r, prod_s;
  logic signed [W-1:0]  corr, cored, summed;
  logic signed [W:0]    corr_x, sum_x;
  logic        [W:0]    mag;

  always_comb begin
    prod   = {{(GW+1){dif[W-1]}}, dif} * {{(W+1){1'b0}}, gain};
    prod_r = prod + RND;
    prod_s = prod_r >>> FRAC;
    corr   = sat_p(prod_s);

    corr_x = {corr[W-1], corr};
    mag    = corr_x[W] ? -corr_x : corr_x;
    cored  = (mag < {1'b0, core}) ? '0 : corr;

    sum_x  = {ctr[W-1], ctr} + {cored[W-1], cored};
    if (sum_x[W] == sum_x[W-1]) summed = sum_x[W-1:0];
    else if (sum_x[W])          summed = {1'b1, {(W-1){1'b0}}};
    else                        summed = {1'b0, {(W-1){1'b1}}};

    if (summed < lo)      res = lo;
    else if (summed > hi) res = hi;
    else                  res = summed;
  end
endmodule

// File: rtl/ces_lane.sv
// One colour-difference lane: window, derivative stage, output stage.
module ces_lane #(
  parameter int W    = 10,
  parameter int GW   = 4,
  parameter int KMAX = 4,
  localparam int KW  = $clog2(KMAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                s1_en,
  input  logic                s2_en,
  input  logic [KW-1:0]       kval,
  input  logic [GW-1:0]       gain,
  input  logic [W-1:0]        core,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout,
  output logic signed [W-1:0] ctr_o,
  output logic signed [W-1:0] lo_o,
  output logic signed [W-1:0] hi_o
);
  logic signed [W-1:0] w_ctr, w_new, w_old, w_lo, w_hi;
  logic signed [W+1:0] dif_x;
  logic signed [W-1:0] dif_d, dif_q;
  logic signed [W-1:0] res_d;

  ces_window #(.W(W), .KMAX(KMAX)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (din),
    .kval     (kval),
    .ctr      (w_ctr),
    .newer    (w_new),
    .older    (w_old),
    .lo       (w_lo),
    .hi       (w_hi)
  );

  // negated second difference, saturated to the sample range
  always_comb begin
    dif_x = {w_ctr[W-1], w_ctr, 1'b0}
          - {{2{w_new[W-1]}}, w_new}
          - {{2{w_old[W-1]}}, w_old};
    if (&dif_x[W+1:W-1] || ~|dif_x[W+1:W-1]) dif_d = dif_x[W-1:0];
    else if (dif_x[W+1])                     dif_d = {1'b1, {(W-1){1'b0}}};
    else                                     dif_d = {1'b0, {(W-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dif_q <= '0;
      ctr_o <= '0;
      lo_o  <= '0;
      hi_o  <= '0;
    end else if (s1_en) begin
      dif_q <= dif_d;
      ctr_o <= w_ctr;
      lo_o  <= w_lo;
      hi_o  <= w_hi;
    end
  end

  ces_shaper #(.W(W), .GW(GW)) u_shp (
    .ctr  (ctr_o),
    .lo   (lo_o),
    .hi   (hi_o),
    .dif  (dif_q),
    .gain (gain),
    .core (core),
    .res  (res_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= '0;
    else if (s2_en) dout <= res_d;
  end
endmodule

// File: rtl/chroma_edge_sharpen.sv
// Top: span decode, strobe pipeline, one lane per colour-difference stream.
module chroma_edge_sharpen
  import ces_pkg::*;
#(
  parameter int W    = 10,
  parameter int GW   = 4,
  parameter int KMAX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_cr,
  input  logic signed [W-1:0] in_cb,
  input  logic [1:0]          span_sel,
  input  logic [GW-1:0]       gain,
  input  logic [W-1:0]        core_lvl,
  output logic                out_valid,
  output logic signed [W-1:0] out_cr,
  output logic signed [W-1:0] out_cb
);
  localparam int KW = $clog2(KMAX + 1);

  logic [KW-1:0]       kval;
  logic                vd1_q, vd2_q, vd3_q;
  logic                vd1_d, vd2_d, vd3_d;
  logic signed [W-1:0] lane_in  [LANES];
  logic signed [W-1:0] lane_out [LANES];
  logic signed [W-1:0] ctr_q    [LANES];
  logic signed [W-1:0] lo_q     [LANES];
  logic signed [W-1:0] hi_q     [LANES];

  always_comb begin
    case (span_e'(span_sel))
      SPAN_NARROW: kval = KW'(1);
      SPAN_MID:    kval = KW'(2);
      default:     kval = KW'(KMAX);
    endcase
  end

  // strobe pipeline: window write, derivative stage, output stage
  always_comb begin
    vd1_d = in_valid;
    vd2_d = vd1_q;
    vd3_d = vd2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd1_q <= 1'b0;
      vd2_q <= 1'b0;
      vd3_q <= 1'b0;
    end else begin
      vd1_q <= vd1_d;
      vd2_q <= vd2_d;
      vd3_q <= vd3_d;
    end
  end

  assign lane_in[0] = in_cr;
  assign lane_in[1] = in_cb;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ces_lane #(.W(W), .GW(GW), .KMAX(KMAX)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .s1_en    (vd1_q),
      .s2_en    (vd2_q),
      .kval     (kval),
      .gain     (gain),
      .core     (core_lvl),
      .din      (lane_in[g]),
      .dout     (lane_out[g]),
      .ctr_o    (ctr_q[g]),
      .lo_o     (lo_q[g]),
      .hi_o     (hi_q[g])
    );
  end

  assign out_valid = vd3_q;
  assign out_cr    = lane_out[0];
  assign out_cb    = lane_out[1];
endmodule

// File: rtl/ces_chk.sv
// Assertion checker bound to the top module.
module ces_chk #(
  parameter int W     = 10,
  parameter int GW    = 4,
  parameter int LANES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                out_valid,
  input logic [GW-1:0]       gain,
  input logic [W-1:0]        core_lvl,
  input logic signed [W-1:0] out_cr,
  input logic signed [W-1:0] out_cb,
  input logic signed [W-1:0] ctr_q [LANES],
  input logic signed [W-1:0] lo_q  [LANES],
  input logic signed [W-1:0] hi_q  [LANES]
);
  localparam logic [W-1:0] MAXMAG = W'(2 ** (W - 1));

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  latency_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age != 2'd0) && !out_valid) |-> ($stable(out_cr) && $stable(out_cb)));

  // R6
  cr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd2) && out_valid) |->
      (($signed(out_cr) >= $signed($past(lo_q[0]))) && ($signed(out_cr) <= $signed($past(hi_q[0])))));

  // R6
  cb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd2) && out_valid) |->
      (($signed(out_cb) >= $signed($past(lo_q[1]))) && ($signed(out_cb) <= $signed($past(hi_q[1])))));

  // R2
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd2) && out_valid && ($past(gain) == '0)) |->
      ((out_cr == $past(ctr_q[0])) && (out_cb == $past(ctr_q[1]))));

  // R5
  core_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age >= 2'd2) && out_valid && ($past(core_lvl) > MAXMAG)) |->
      ((out_cr == $past(ctr_q[0])) && (out_cb == $past(ctr_q[1]))));
endmodule

bind chroma_edge_sharpen ces_chk #(.W(W), .GW(GW), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .gain      (gain),
  .core_lvl  (core_lvl),
  .out_cr    (out_cr),
  .out_cb    (out_cb),
  .ctr_q     (ctr_q),
  .lo_q      (lo_q),
  .hi_q      (hi_q)
);

// File: tb/sim_chroma_edge_sharpen.sv
`timescale 1ns/1ps
module sim_chroma_edge_sharpen;
  localparam int W    = 10;
  localparam int GW   = 4;
  localparam int KMAX = 4;
  localparam int SMIN = -(2 ** (W - 1));
  localparam int SMAX = 2 ** (W - 1) - 1;
  localparam int HN   = 8192;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic signed [W-1:0] in_cr, in_cb;
  logic [1:0]          span_sel;
  logic [GW-1:0]       gain;
  logic [W-1:0]        core_lvl;
  logic                out_valid;
  logic signed [W-1:0] out_cr, out_cb;

  always #2 clk = ~clk;

  chroma_edge_sharpen #(.W(W), .GW(GW), .KMAX(KMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cr(in_cr), .in_cb(in_cb),
    .span_sel(span_sel), .gain(gain), .core_lvl(core_lvl),
    .out_valid(out_valid), .out_cr(out_cr), .out_cb(out_cb)
  );

  int checks = 0;
  int bad    = 0;
  int hcr [HN];
  int hcb [HN];
  int ecr [HN];
  int ecb [HN];
  int nsamp = 0, rd = 0;
  int cfg_k = 1, cfg_g = 0, cfg_c = 0;
  bit dv0 = 0, dv1 = 0, dv2 = 0;
  int last_cr = 0, last_cb = 0;
  string tag = "R3";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic int hv(int lane, int i);
    if (i < 0) return 0;
    return (lane == 0) ? hcr[i] : hcb[i];
  endfunction

  // expected output for the sample accepted as number n
  function automatic int model(int lane, int n);
    int c, a, b, d, r, corr, mag, s, lo, hi;
    c = hv(lane, n - KMAX);
    a = hv(lane, n - KMAX + cfg_k);
    b = hv(lane, n - KMAX - cfg_k);
    d = sat(2 * c - a - b);
    r = (d * cfg_g + 4) >>> 3;
    corr = sat(r);
    mag = (corr < 0) ? -corr : corr;
    if (mag < cfg_c) corr = 0;
    s = sat(c + corr);
    lo = c; hi = c;
    for (int j = -cfg_k; j <= cfg_k; j++) begin
      if (hv(lane, n - KMAX + j) < lo) lo = hv(lane, n - KMAX + j);
      if (hv(lane, n - KMAX + j) > hi) hi = hv(lane, n - KMAX + j);
    end
    if (s < lo) s = lo;
    if (s > hi) s = hi;
    return s;
  endfunction

  task automatic tick(bit v, int cr, int cb);
    @(negedge clk);
    chk("R1", int'(out_valid), int'(dv2));
    if (dv2) begin
      chk(tag, int'(out_cr), ecr[rd]);
      chk("R7", int'(out_cb), ecb[rd]);
      last_cr = int'(out_cr);
      last_cb = int'(out_cb);
      rd++;
    end else begin
      chk("R8", int'(out_cr), last_cr);
      chk("R8", int'(out_cb), last_cb);
    end
    dv2 = dv1; dv1 = dv0; dv0 = v;
    in_valid = v;
    in_cr = W'(cr);
    in_cb = W'(cb);
    if (v) begin
      hcr[nsamp] = cr;
      hcb[nsamp] = cb;
      ecr[nsamp] = model(0, nsamp);
      ecb[nsamp] = model(1, nsamp);
      nsamp++;
    end
  endtask

  task automatic set_cfg(int sp, int g, int c);
    for (int i = 0; i < 4; i++) tick(1'b0, 0, 0);
    span_sel = 2'(sp);
    gain     = GW'(g);
    core_lvl = W'(c);
    cfg_k    = (sp == 0) ? 1 : (sp == 1) ? 2 : 4;
    cfg_g    = g;
    cfg_c    = c;
  endtask

  function automatic int rs();
    return int'($urandom_range(2 ** W - 1)) + SMIN;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_cr = '0; in_cb = '0;
    span_sel = 2'b00; gain = '0; core_lvl = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", int'(out_valid), 0);
    chk("R9", int'(out_cr), 0);
    chk("R9", int'(out_cb), 0);
    rst_n = 1'b1;

    // R3/R6: steps at each span code, unity gain
    tag = "R3";
    for (int sp = 0; sp < 4; sp++) begin
      set_cfg(sp, 8, 0);
      for (int i = 0; i < 12; i++) tick(1'b1, -300, 40 * i - 200);
      for (int i = 0; i < 12; i++) tick(1'b1, 300, 100 - 20 * i);
      for (int i = 0; i < 6; i++)  tick(1'b1, -100, 7);
    end

    // R4: saturation and rounding at full gain with extreme samples
    tag = "R4";
    set_cfg(0, 15, 0);
    for (int i = 0; i < 16; i++) tick(1'b1, (i % 2) ? SMAX : SMIN, (i % 3 == 0) ? SMIN : SMAX);
    set_cfg(2, 15, 0);
    for (int i = 0; i < 10; i++) tick(1'b1, SMIN, 3);
    for (int i = 0; i < 10; i++) tick(1'b1, SMAX, -3);

    // R5: coring at several levels, including the boundary and full kill
    tag = "R5";
    for (int c = 0; c < 5; c++) begin
      set_cfg(1, 12, (c == 4) ? 600 : c * 20);
      for (int i = 0; i < 30; i++) tick(1'b1, int'($urandom_range(200)) - 100, rs());
    end

    // R2: zero gain passes the delayed centre sample
    tag = "R2";
    set_cfg(2, 0, 0);
    for (int i = 0; i < 30; i++) tick(1'b1, rs(), rs());

    // R6: random configuration, random strobe gaps
    tag = "R6";
    for (int b = 0; b < 40; b++) begin
      set_cfg(int'($urandom_range(3)), int'($urandom_range(15)),
              ($urandom_range(7) == 0) ? 700 : int'($urandom_range(63)));
      for (int i = 0; i < 10 + int'($urandom_range(30)); i++)
        tick(($urandom_range(9) < 7), rs(), rs());
    end

    for (int i = 0; i < 5; i++) tick(1'b0, 0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule